// File: doc/BRIEF.md
# Streaming Zero Padding Inserter

This block sits in a pixel-streaming feature-map pipeline in front of a convolution stage. It takes a square map of side `IMG_SIDE` pixels and emits a square map of side `KERNEL + STRIDE*(IMG_SIDE/STRIDE - 1)`. That is the size that lets a window of `KERNEL` pixels, stepped by `STRIDE`, produce one result per stride step of the original image. Every beat on either stream is one whole pixel: `CHANNELS` elements of `ELEM_BITS` bits each, with channel `c` in bits `[c*ELEM_BITS +: ELEM_BITS]`. Pixels travel in row-major order on both sides.

The block tracks which output position it is generating next. Border positions get an all-zero pixel and take nothing from the input. Interior positions take the next input pixel and pass it through unchanged. The extra rows and columns split evenly between the two sides of each axis. When the total is odd, the top and the left each take the larger half. After `IMAGES` complete maps the block stops producing output and stops accepting input until it is reset. Both streams use a valid/ready handshake, and there is no start or done control. Elaboration stops with an error if `STRIDE` does not divide `IMG_SIDE`, or if the output would be smaller than the input.

Top module: `zpad_inserter`

## Requirements
- R1: Each image produces exactly `OUT*OUT` output beats and consumes exactly `IMG_SIDE*IMG_SIDE` input beats, where `OUT = KERNEL + STRIDE*(IMG_SIDE/STRIDE - 1)`.
- R2: When the total pad `P = OUT - IMG_SIDE` is odd, the first `(P+1)/2` rows and columns are border and the last `(P-1)/2` rows and columns are border.
- R3: When `P` is even, `P/2` border rows and columns are placed on each side of each axis.
- R4: Every border beat has the value zero in every channel.
- R5: Interior beats carry the input pixels in arrival order, unchanged, with channel `c` staying in bits `[c*ELEM_BITS +: ELEM_BITS]`.
- R6: `in_ready` is high exactly when the block has not finished, the next position to generate is interior, and the output register is empty or is being read in the same cycle. Border beats consume no input.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values into the next cycle.
- R8: After `IMAGES` whole images, `out_valid` and `in_ready` stay low regardless of the inputs.
- R9: While `rst_n` is low, `out_valid` is low.
- R10: With `in_valid` and `out_ready` held high from reset release, one beat leaves every cycle after the first, with no gap, until all images are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when high together with in_valid |
| in_data | input | CHANNELS*ELEM_BITS | Input pixel, all channels packed |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_data | output | CHANNELS*ELEM_BITS | Output pixel, all channels packed |

## Verification
The bound checker keeps its own output-position count from completed output handshakes. Against that count it checks, on every cycle, that border beats are zero, that a stalled beat holds, and that an accepted pixel appears at the output on the next cycle. It also checks that `in_ready` never rises while the output register is blocked, and that the block is silent once every image has been delivered. Some behaviour is only visible to the bench's scenarios: that the pad splits correctly for both an odd and an even total, that beat and pixel counts per image are exact, that `in_ready` matches the interior map at each position under random stalls, and that full throughput leaves no bubble.

// File: rtl/zpad_pkg.sv
package zpad_pkg;

  // Side length of the padded map for a given kernel and stride.
  function automatic int zp_out_side(input int side_in, input int kern, input int strd);
    return kern + strd * ((side_in / strd) - 1);
  endfunction

  // Leading (top/left) pad: the larger half when the total is odd.
  function automatic int zp_lead_pad(input int total_pad);
    return (total_pad + 1) / 2;
  endfunction

  // Counter width that stays legal for a count limit of one.
  function automatic int zp_cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/zpad_pos_counter.sv
module zpad_pos_counter
  import zpad_pkg::*;
#(
  parameter int SIDE   = 7,
  parameter int IMAGES = 2,
  parameter int CW     = zp_cnt_width(SIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] row,
  output logic [CW-1:0] col,
  output logic          finished
);

  localparam int IW = zp_cnt_width(IMAGES);

  logic [CW-1:0] row_q, row_n;
  logic [CW-1:0] col_q, col_n;
  logic [IW-1:0] img_q, img_n;
  logic          fin_q, fin_n;
  logic          col_last, row_last, img_last;

  assign col_last = (col_q == CW'(SIDE - 1));
  assign row_last = (row_q == CW'(SIDE - 1));
  assign img_last = (img_q == IW'(IMAGES - 1));

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    img_n = img_q;
    fin_n = fin_q;
    if (step && !fin_q) begin
      if (!col_last) begin
        col_n = col_q + 1'b1;
      end else begin
        col_n = '0;
        if (!row_last) begin
          row_n = row_q + 1'b1;
        end else begin
          row_n = '0;
          if (!img_last) begin
            img_n = img_q + 1'b1;
          end else begin
            img_n = '0;
            fin_n = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      img_q <= '0;
      fin_q <= 1'b0;
    end else begin
      row_q <= row_n;
      col_q <= col_n;
      img_q <= img_n;
      fin_q <= fin_n;
    end
  end

  assign row      = row_q;
  assign col      = col_q;
  assign finished = fin_q;

endmodule

// File: rtl/zpad_region.sv
module zpad_region #(
  parameter int SIDE_IN = 6,
  parameter int LEAD    = 1,
  parameter int CW      = 3
) (
  input  logic [CW-1:0] row,
  input  logic [CW-1:0] col,
  output logic          interior
);

  logic [CW-1:0] coord [2];
  logic [1:0]    axis_in;

  assign coord[0] = row;
  assign coord[1] = col;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    assign axis_in[a] = (int'(coord[a]) >= LEAD) && (int'(coord[a]) < LEAD + SIDE_IN);
  end

  assign interior = &axis_in;

endmodule

// File: rtl/zpad_out_stage.sv
module zpad_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [PW-1:0] out_data,
  output logic          slot_free
);

  logic          vld_q, vld_n;
  logic [PW-1:0] dat_q;
  logic          dat_en;

  always_comb begin
    vld_n  = vld_q;
    dat_en = load;
    if (load) begin
      vld_n = 1'b1;
    end else if (out_ready) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_en) begin
      dat_q <= load_data;
    end
  end

  assign slot_free = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/zpad_inserter.sv
module zpad_inserter
  import zpad_pkg::*;
#(
  parameter int IMG_SIDE  = 6,
  parameter int KERNEL    = 3,
  parameter int STRIDE    = 2,
  parameter int CHANNELS  = 2,
  parameter int ELEM_BITS = 4,
  parameter int IMAGES    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CHANNELS*ELEM_BITS-1:0] in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [CHANNELS*ELEM_BITS-1:0] out_data
);

  localparam int OUT_SIDE = zp_out_side(IMG_SIDE, KERNEL, STRIDE);
  localparam int LEAD     = zp_lead_pad(OUT_SIDE - IMG_SIDE);
  localparam int CW       = zp_cnt_width(OUT_SIDE);
  localparam int PW       = CHANNELS * ELEM_BITS;

  if (IMG_SIDE % STRIDE != 0) begin : g_bad_stride
    $error("zpad_inserter: STRIDE must divide IMG_SIDE");
  end
  if (OUT_SIDE < IMG_SIDE) begin : g_bad_kernel
    $error("zpad_inserter: padded side smaller than input side");
  end

  logic [CW-1:0] gen_row, gen_col;
  logic          finished;
  logic          interior;
  logic          slot_free;
  logic          gen_ok;
  logic          step;
  logic [PW-1:0] fill_data;

  zpad_pos_counter #(
    .SIDE  (OUT_SIDE),
    .IMAGES(IMAGES),
    .CW    (CW)
  ) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .row     (gen_row),
    .col     (gen_col),
    .finished(finished)
  );

  zpad_region #(
    .SIDE_IN(IMG_SIDE),
    .LEAD   (LEAD),
    .CW     (CW)
  ) u_region (
    .row     (gen_row),
    .col     (gen_col),
    .interior(interior)
  );

  // Per-channel lane: pass the input element inside, zero on the border.
  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    assign fill_data[c*ELEM_BITS +: ELEM_BITS] =
      interior ? in_data[c*ELEM_BITS +: ELEM_BITS] : '0;
  end

  assign gen_ok   = !finished && slot_free;
  assign in_ready = gen_ok && interior;
  assign step     = gen_ok && (!interior || in_valid);

  zpad_out_stage #(
    .PW(PW)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step),
    .load_data(fill_data),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .slot_free(slot_free)
  );

endmodule

// File: rtl/zpad_inserter_chk.sv
module zpad_inserter_chk
  import zpad_pkg::*;
#(
  parameter int IMG_SIDE  = 6,
  parameter int KERNEL    = 3,
  parameter int STRIDE    = 2,
  parameter int CHANNELS  = 2,
  parameter int ELEM_BITS = 4,
  parameter int IMAGES    = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [CHANNELS*ELEM_BITS-1:0] in_data,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [CHANNELS*ELEM_BITS-1:0] out_data
);

  localparam int OUT_SIDE = zp_out_side(IMG_SIDE, KERNEL, STRIDE);
  localparam int LEAD     = zp_lead_pad(OUT_SIDE - IMG_SIDE);

  // Position of the beat currently on the output, counted from handshakes.
  int   orow, ocol, oimg;
  logic odone;
  logic o_border;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orow  <= 0;
      ocol  <= 0;
      oimg  <= 0;
      odone <= 1'b0;
    end else if (out_valid && out_ready && !odone) begin
      if (ocol != OUT_SIDE - 1) begin
        ocol <= ocol + 1;
      end else begin
        ocol <= 0;
        if (orow != OUT_SIDE - 1) begin
          orow <= orow + 1;
        end else begin
          orow <= 0;
          if (oimg != IMAGES - 1) oimg <= oimg + 1;
          else odone <= 1'b1;
        end
      end
    end
  end

  assign o_border = !((orow >= LEAD) && (orow < LEAD + IMG_SIDE) &&
                      (ocol >= LEAD) && (ocol < LEAD + IMG_SIDE));

  assert_border_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_border) |-> (out_data == '0));

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  assert_ready_needs_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    odone |-> (!out_valid && !in_ready));

endmodule

bind zpad_inserter zpad_inserter_chk #(
  .IMG_SIDE (IMG_SIDE),
  .KERNEL   (KERNEL),
  .STRIDE   (STRIDE),
  .CHANNELS (CHANNELS),
  .ELEM_BITS(ELEM_BITS),
  .IMAGES   (IMAGES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/zpad_harness.sv
module zpad_harness #(
  parameter int          N      = 6,
  parameter int          K      = 3,
  parameter int          S      = 2,
  parameter int          C      = 2,
  parameter int          EB     = 4,
  parameter int          REPS   = 2,
  parameter string       PADREQ = "R2",
  parameter int unsigned SEED   = 1
) (
  input  logic clk,
  output logic finished_o
);

  localparam int OUT  = K + S * (N / S - 1);
  localparam int PADT = OUT - N;
  localparam int LEAD = (PADT % 2 == 0) ? PADT / 2 : PADT / 2 + 1;
  localparam int W    = C * EB;
  localparam int NIN  = REPS * N * N;
  localparam int NOUT = REPS * OUT * OUT;

  logic         rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] in_data, out_data;
  logic [W-1:0] mem [NIN];
  int           checks, errors;

  zpad_inserter #(
    .IMG_SIDE(N), .KERNEL(K), .STRIDE(S),
    .CHANNELS(C), .ELEM_BITS(EB), .IMAGES(REPS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic bit is_in(input int r, input int c);
    return (r >= LEAD) && (r < LEAD + N) && (c >= LEAD) && (c < LEAD + N);
  endfunction

  function automatic bit beat_in(input int b);
    int rem;
    rem = b % (OUT * OUT);
    return is_in(rem / OUT, rem % OUT);
  endfunction

  function automatic logic [W-1:0] exp_pix(input int b);
    int img, rem, r, c;
    img = b / (OUT * OUT);
    rem = b % (OUT * OUT);
    r   = rem / OUT;
    c   = rem % OUT;
    if (is_in(r, c)) return mem[img*N*N + (r - LEAD)*N + (c - LEAD)];
    return '0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s (N=%0d K=%0d S=%0d): actual %0h expected %0h",
               req, what, N, K, S, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    in_data   = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NIN; i++) mem[i] = W'($urandom);
  endtask

  task automatic run_stream(input int vpct, input int rpct, input bit full);
    int           fin, fout, gaps, cyc, gen;
    bit           seen, hold_pend, exp_rdy;
    logic [W-1:0] hold_d;
    fin = 0; fout = 0; gaps = 0; cyc = 0; seen = 0; hold_pend = 0; hold_d = '0;
    while (fout < NOUT && cyc < 20000) begin
      in_valid  = (int'($urandom % 100) < vpct);
      out_ready = (int'($urandom % 100) < rpct);
      in_data   = (fin < NIN) ? mem[fin] : '0;
      #1;
      if (hold_pend)
        chk(out_valid === 1'b1 && out_data === hold_d, "R7", "stalled beat changed",
            longint'(out_data), longint'(hold_d));
      gen     = fout + (out_valid ? 1 : 0);
      exp_rdy = (gen < NOUT) && beat_in(gen) && (!out_valid || out_ready);
      chk(in_ready === exp_rdy, beat_in(gen) ? "R6" : $sformatf("R6 %s", PADREQ),
          $sformatf("in_ready at beat %0d", gen), longint'(in_ready), longint'(exp_rdy));
      if (full && seen && !out_valid) gaps++;
      if (out_valid) seen = 1;
      if (out_valid && out_ready) begin
        chk(out_data === exp_pix(fout),
            beat_in(fout) ? "R5" : $sformatf("R4 %s", PADREQ),
            $sformatf("out_data at beat %0d", fout),
            longint'(out_data), longint'(exp_pix(fout)));
        fout++;
      end
      hold_pend = out_valid && !out_ready;
      hold_d    = out_data;
      if (in_valid && in_ready) fin++;
      @(negedge clk);
      cyc++;
    end
    chk(fout == NOUT, "R1", "output beats", fout, NOUT);
    chk(fin == NIN, "R1", "input beats consumed", fin, NIN);
    if (full) begin
      chk(gaps == 0, "R10", "bubbles at full rate", gaps, 0);
      chk(cyc == NOUT + 1, "R10", "cycles at full rate", cyc, NOUT + 1);
    end
    for (int i = 0; i < 10; i++) begin
      in_valid  = 1'b1;
      out_ready = (i % 3) != 0;
      #1;
      chk(!out_valid && !in_ready, "R8", "activity after last image",
          longint'({out_valid, in_ready}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    finished_o = 1'b0;
    checks     = 0;
    errors     = 0;
    void'($urandom(SEED));
    @(negedge clk);
    do_reset();
    fill_mem();
    run_stream(70, 60, 1'b0);
    do_reset();
    fill_mem();
    run_stream(100, 100, 1'b1);
    do_reset();
    fill_mem();
    run_stream(30, 90, 1'b0);
    finished_o = 1'b1;
  end

endmodule

// File: tb/zpad_inserter_tb.sv
module zpad_inserter_tb;

  logic clk;
  logic fin_odd, fin_even;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Odd total pad (R2): 6x6 -> 7x7, one leading border line per axis.
  zpad_harness #(
    .N(6), .K(3), .S(2), .C(2), .EB(4), .REPS(2), .PADREQ("R2"), .SEED(11)
  ) h_odd (
    .clk(clk), .finished_o(fin_odd)
  );

  // Even total pad (R3): 4x4 -> 8x8, two border lines on every side.
  zpad_harness #(
    .N(4), .K(5), .S(1), .C(3), .EB(3), .REPS(2), .PADREQ("R3"), .SEED(23)
  ) h_even (
    .clk(clk), .finished_o(fin_even)
  );

  initial begin
    int cyc;
    int checks, errors;
    cyc = 0;
    while (!(fin_odd === 1'b1 && fin_even === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    checks = h_odd.checks + h_even.checks + 1;
    errors = h_odd.errors + h_even.errors;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule